// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes over an asynchronous serial line. A host places a byte in a one-entry holding buffer. The byte then moves into a separate shift register, and the shift register clocks it out as an NRZ frame. A start bit (low) leads the frame. Eight or nine data bits follow, least significant first, and a stop bit (high) closes it. Because the buffer and the shift register are separate, the host can queue the next byte while the current one is on the line, so frames can follow each other without a gap imposed by the host.

Bit timing comes from an internal divider with a reloadable 8-bit rate value. Each divider terminal count gives one tick. A bit lasts 16 ticks or 64 ticks, depending on a speed-select control bit. The block has two status flags: one says the holding buffer is empty, the other says the shift register is empty. It also drives an interrupt request, which is the buffer-empty flag gated by an interrupt-enable bit. Two enables control the line. Clearing the transmit enable aborts any frame in progress. With the port enable low, the output-enable is released.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `ser_oe` is 0, `buf_empty` is 0, `shreg_empty` is 1, `irq` is 0 and `ser_out` is 1.
- R2: A frame is one low start bit, then the data bits with bit 0 first, then one high stop bit. Each bit lasts 16 ticks when control bit 2 is 1, or 64 ticks when it is 0. A tick occurs once every rate+1 clocks, where rate is the last value written through `rate_in`.
- R3: When control bit 1 (nine-bit mode) is set, a ninth data bit follows bit 7. Its value is control bit 4 as it stands when the byte moves into the shift register, not as it stood when the byte was written.
- R4: A byte written while the shift register is idle and transmission is enabled moves into the shift register on the next clock. `buf_empty` rises one clock after that move, and `shreg_empty` falls one clock after it. `shreg_empty` rises again once the stop bit is complete.
- R5: A byte written while a frame is in flight waits in the buffer, with `buf_empty` low, until that frame's stop bit is sent. It is then sent as the next frame, and no byte is lost.
- R6: `buf_empty` falls only on a data write. It rises when transmission is enabled (control bit 0) and the buffer is empty. Control bit 5 (interrupt enable) does not change it.
- R7: `irq` is high exactly when `buf_empty` is high and control bit 5 is 1.
- R8: While control bit 0 is 0, nothing is sent. A byte written in that state stays in the buffer and is sent after control bit 0 is set.
- R9: Clearing control bit 0 in the middle of a frame drops `ser_oe` in the same cycle and stops the frame. `shreg_empty` rises two clocks after the control write, and no remainder of the frame appears once transmission is re-enabled.
- R10: `ser_oe` is high only while both control bit 3 (port enable) and control bit 0 are 1. When no frame is being shifted, `ser_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_we | input | 1 | Write strobe for the holding buffer |
| data_in | input | DW | Byte to send |
| rate_we | input | 1 | Write strobe for the divider rate; restarts the divider count |
| rate_in | input | RW | Divider rate; a tick occurs every rate+1 clocks |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_in | input | 6 | Bit 0 transmit enable, 1 nine-bit mode, 2 fast (16 ticks/bit), 3 port enable, 4 ninth-bit value, 5 interrupt enable |
| ser_out | output | 1 | Serial line value |
| ser_oe | output | 1 | Drive enable for the serial line; low means high impedance |
| buf_empty | output | 1 | Holding buffer empty flag |
| shreg_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default widths, DW=8 and RW=8. At run time it programs small rate values: rate 1 in 16-tick mode gives 32-clock bits, and rate 0 in 64-tick mode gives 64-clock bits. With bits this short, whole 8- and 9-bit frames, back-to-back pairs and a mid-frame abort all fit in a few thousand cycles. Because the bits are short, every flag delay can be checked to the exact clock, while the mid-bit line samples still have a wide margin on both sides.

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          rate_we,
  input  logic [RW-1:0] rate_in,
  input  logic          ctl_we,
  input  logic [5:0]    ctl_in,
  output logic          ser_out,
  output logic          ser_oe,
  output logic          buf_empty,
  output logic          shreg_empty,
  output logic          irq
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RUN} phase_t;

  logic [RW-1:0] rate_q, div_q;
  logic          xmit_on, nine_on, fast_on, port_on, bit9_q, irq_on;
  logic [DW-1:0] hold_q;
  logic          hold_full;
  logic [FW-1:0] shr_q;
  logic [IW-1:0] bit_idx, last_idx;
  logic [5:0]    sub_q;
  phase_t        phase;
  logic          tick, load, sub_end;

  assign tick    = (div_q == rate_q);
  assign sub_end = (sub_q == (fast_on ? 6'd15 : 6'd63));
  assign load    = xmit_on && hold_full && (phase == PH_IDLE);

  assign ser_oe  = port_on & xmit_on;
  assign ser_out = (phase == PH_RUN) ? shr_q[0] : 1'b1;
  assign irq     = buf_empty & irq_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      div_q  <= '0;
    end else if (rate_we) begin
      rate_q <= rate_in;
      div_q  <= '0;
    end else if (tick) begin
      div_q  <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {irq_on, bit9_q, port_on, fast_on, nine_on, xmit_on} <= '0;
    end else if (ctl_we) begin
      {irq_on, bit9_q, port_on, fast_on, nine_on, xmit_on} <= ctl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      buf_empty <= 1'b0;
    end else begin
      if (data_we) begin
        hold_q    <= data_in;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (data_we)
        buf_empty <= 1'b0;
      else if (xmit_on && !hold_full)
        buf_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      shr_q    <= '1;
      bit_idx  <= '0;
      last_idx <= '0;
      sub_q    <= '0;
    end else if (!xmit_on) begin
      phase    <= PH_IDLE;
      bit_idx  <= '0;
      sub_q    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (load) begin
          shr_q    <= {1'b1, (nine_on ? bit9_q : 1'b1), hold_q, 1'b0};
          last_idx <= nine_on ? IW'(FW - 1) : IW'(FW - 2);
          phase    <= PH_WAIT;
        end
        PH_WAIT: if (tick) begin
          phase   <= PH_RUN;
          sub_q   <= '0;
          bit_idx <= '0;
        end
        PH_RUN: if (tick) begin
          if (sub_end) begin
            sub_q <= '0;
            shr_q <= {1'b1, shr_q[FW-1:1]};
            if (bit_idx == last_idx) phase <= PH_IDLE;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_empty <= 1'b1;
    else        shreg_empty <= (phase == PH_IDLE);
  end

  // R6
  buf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(data_we));
  // R4
  shr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shreg_empty) |-> $past(hold_full, 2));
  // R4
  buf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) && !data_we && xmit_on |=> buf_empty);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_on |=> phase == PH_IDLE);
  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RUN |-> bit_idx <= last_idx);
endmodule

// File: tb/sertx_dbuf_tb.sv
`timescale 1ns/1ps
module sertx_dbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic data_we = 1'b0, rate_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] data_in = '0, rate_in = '0;
  logic [5:0] ctl_in = '0;
  logic ser_out, ser_oe, buf_empty, shreg_empty, irq;

  int total = 0, bad = 0, rx_cnt = 0, bit_clks = 32;
  bit mon_on = 1'b1, done = 1'b0;
  bit [9:0] exp_q[$];

  always #4 clk = ~clk;

  sertx_dbuf u_dut (.clk(clk), .rst_n(rst_n), .data_we(data_we), .data_in(data_in),
    .rate_we(rate_we), .rate_in(rate_in), .ctl_we(ctl_we), .ctl_in(ctl_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .buf_empty(buf_empty),
    .shreg_empty(shreg_empty), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] cv(bit x, bit n9, bit fast, bit port, bit b9, bit ie);
    return {ie, b9, port, fast, n9, x};
  endfunction

  task automatic put_ctl(input logic [5:0] v);
    @(negedge clk); ctl_in = v; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic put_rate(input logic [7:0] v);
    @(negedge clk); rate_in = v; rate_we = 1'b1;
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit n9, input bit b9);
    exp_q.push_back({n9, b9, d});
    @(negedge clk); data_in = d; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  // scoreboard monitor: samples each bit at its middle
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && ser_oe && !ser_out) begin
        bit [9:0] e;
        logic [8:0] got;
        int n;
        got = '0;
        repeat (bit_clks / 2) @(negedge clk);
        check("R2 start bit", ser_out, 1'b0);
        if (exp_q.size() == 0) begin
          e = '0;
          check("R2 unexpected frame", 1, 0);
        end else begin
          e = exp_q.pop_front();
        end
        n = e[9] ? 9 : 8;
        for (int i = 0; i < n; i++) begin
          repeat (bit_clks) @(negedge clk);
          got[i] = ser_out;
        end
        repeat (bit_clks) @(negedge clk);
        check("R2 stop bit", ser_out, 1'b1);
        if (e[9]) check("R3 nine-bit frame data", got, e[8:0]);
        else      check("R2/R5 frame data", got[7:0], e[7:0]);
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", ser_oe, 0);
    check("R1 buf_empty", buf_empty, 0);
    check("R1 shreg_empty", shreg_empty, 1);
    check("R1 irq", irq, 0);
    check("R1 line", ser_out, 1);

    put_rate(8'd1); bit_clks = 32;
    put_ctl(cv(1, 0, 1, 1, 0, 0));
    check("R6 flag one clock late", buf_empty, 0);
    @(negedge clk);
    check("R6 set on enable", buf_empty, 1);
    check("R7 irq masked", irq, 0);
    check("R10 oe on", ser_oe, 1);
    check("R10 idle mark", ser_out, 1);
    put_ctl(cv(1, 0, 1, 1, 0, 1));
    check("R7 irq", irq, 1);
    check("R6 ie no effect", buf_empty, 1);

    send(8'hA5, 0, 0);
    check("R4 buf cleared", buf_empty, 0);
    check("R4 shr still empty", shreg_empty, 1);
    check("R7 irq low", irq, 0);
    @(negedge clk);
    check("R4 buf one clock late", buf_empty, 0);
    check("R4 shr one clock late", shreg_empty, 1);
    @(negedge clk);
    check("R4 buf set", buf_empty, 1);
    check("R4 shr loaded", shreg_empty, 0);

    send(8'h3C, 0, 0);
    repeat (100) @(negedge clk);
    check("R5 held", buf_empty, 0);
    wait_frames(2);
    repeat (2 * bit_clks) @(negedge clk);
    check("R4 shr idle after frames", shreg_empty, 1);
    check("R5 buf idle after frames", buf_empty, 1);

    put_ctl(cv(1, 1, 1, 1, 1, 1));
    send(8'h5A, 1, 1);
    repeat (10) @(negedge clk);
    send(8'hC3, 1, 0);
    put_ctl(cv(1, 1, 1, 1, 0, 1));
    wait_frames(4);
    repeat (2 * bit_clks) @(negedge clk);

    put_rate(8'd0); bit_clks = 64;
    put_ctl(cv(1, 0, 0, 1, 0, 1));
    send(8'h81, 0, 0);
    wait_frames(5);
    repeat (2 * bit_clks) @(negedge clk);

    put_rate(8'd1); bit_clks = 32;
    put_ctl(cv(0, 0, 1, 1, 0, 1));
    @(negedge clk); data_in = 8'h6E; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    repeat (80) @(negedge clk);
    check("R8 oe off", ser_oe, 0);
    check("R8 nothing loaded", shreg_empty, 1);
    check("R8 byte held", buf_empty, 0);
    exp_q.push_back({1'b0, 1'b0, 8'h6E});
    put_ctl(cv(1, 0, 1, 1, 0, 1));
    wait_frames(6);
    repeat (2 * bit_clks) @(negedge clk);

    put_ctl(cv(1, 0, 1, 0, 0, 1));
    check("R10 port off", ser_oe, 0);
    put_ctl(cv(1, 0, 1, 1, 0, 1));
    check("R10 port on", ser_oe, 1);

    mon_on = 1'b0;
    @(negedge clk); data_in = 8'h00; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
    repeat (3 * bit_clks) @(negedge clk);
    check("R9 mid frame busy", shreg_empty, 0);
    check("R9 mid frame oe", ser_oe, 1);
    put_ctl(cv(0, 0, 1, 1, 0, 1));
    check("R9 oe dropped", ser_oe, 0);
    @(negedge clk);
    check("R9 shr not yet", shreg_empty, 0);
    @(negedge clk);
    check("R9 shr empty", shreg_empty, 1);
    put_ctl(cv(1, 0, 1, 1, 0, 1));
    lows = 0;
    repeat (400) begin
      @(negedge clk);
      if (!ser_out) lows++;
    end
    check("R9 no remainder", lows, 0);
    check("R9 shr stays empty", shreg_empty, 1);
    check("R9 buf empty", buf_empty, 1);
    check("R9 queue drained", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule